// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst on a synchronous SRAM port. A new burst starts when one of two active-low address strobes is seen on a rising clock edge. One strobe is meant for the processor and is gated by the primary chip enable. The other is meant for the cache controller and is always accepted. The sampled address becomes the burst base. The burst order is also captured in that same cycle.

After the load, the two low address bits move one beat forward on each rising edge where the active-low advance input is low. The upper bits never change during a burst. In interleaved order the low bits are the base low bits XOR the beat count. In linear order they are the base low bits plus the count, modulo four, so the burst wraps inside its aligned group of four.

On the fourth beat, `last_beat` goes high and the counter stops there until the next strobe. All outputs come from registers, and each one changes one clock after the edge that samples its cause. The ports are plain control pins: nothing is streamed, so there is no valid/ready handshake and no back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `addr_out` is 0 and `last_beat` is 0.
- R2: When `ads_ctrl_n` is low at a rising edge, `addr_out` equals the sampled `addr_in` after that edge, whatever the level of `chip_en_n`.
- R3: When `ads_proc_n` and `chip_en_n` are both low at a rising edge, `addr_out` equals the sampled `addr_in` after that edge.
- R4: When `ads_proc_n` is low while `chip_en_n` is high, the processor strobe has no effect. If `ads_ctrl_n` and `adv_n` are also high, `addr_out` and `last_beat` keep their values.
- R5: With no strobe accepted, an edge with `adv_n` low moves the burst one beat forward. An edge with `adv_n` high holds `addr_out`.
- R6: When `lin_mode` was 0 at the load edge (interleaved), `addr_out[1:0]` equals the base `[1:0]` XOR the beat count (0 to 3).
- R7: When `lin_mode` was 1 at the load edge (linear), `addr_out[1:0]` equals (base `[1:0]` + beat count) mod 4. Changing `lin_mode` during a burst has no effect.
- R8: `addr_out[ADDR_W-1:2]` stays equal to the base upper bits until a new strobe is accepted.
- R9: `last_beat` is 1 exactly when the beat count is 3. Further advances leave `addr_out` and `last_beat` unchanged until a new strobe is accepted.
- R10: An accepted strobe in the same cycle as `adv_n` low loads a new burst at count 0. The advance is discarded.
- R11: Advances before the first accepted strobe after reset have no effect: `addr_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External address, sampled on a strobe |
| ads_proc_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| ads_ctrl_n | input | 1 | Controller address strobe, active low, always accepted |
| chip_en_n | input | 1 | Primary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| lin_mode | input | 1 | Burst order: 0 interleaved, 1 linear; captured at load |
| addr_out | output | ADDR_W | Current beat address |
| last_beat | output | 1 | High on the fourth beat of the burst |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before operation begins. They also assume that every input is settled at each rising edge, because the past-value checks compare values from one edge to the next. The bench changes every input only at the falling edge, keeps reset low for several cycles, and only then mixes directed bursts with random strobe, enable, advance and mode patterns. Its cycle-level model predicts `addr_out` and `last_beat` after every edge from the inputs alone.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic {
    ORD_XOR  = 1'b0,
    ORD_WRAP = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bas_strobe_ctrl.sv
module bas_strobe_ctrl (
  input  logic ads_proc_n,
  input  logic ads_ctrl_n,
  input  logic chip_en_n,
  input  logic adv_n,
  output logic load,
  output logic adv_req
);
  logic proc_ok;

  always_comb begin
    proc_ok = !ads_proc_n && !chip_en_n;
    load    = proc_ok || !ads_ctrl_n;
    adv_req = !adv_n && !load;
  end
endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv_req,
  output logic [CNT_W-1:0] count,
  output logic             armed,
  output logic             at_end
);
  logic [CNT_W-1:0] count_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      count_q <= '0;
      armed_q <= 1'b1;
    end else if (adv_req && armed_q && !(&count_q)) begin
      count_q <= count_q + 1'b1;
    end
  end

  always_comb begin
    count  = count_q;
    armed  = armed_q;
    at_end = armed_q && (&count_q);
  end

  // R5: an accepted advance moves the count by exactly one
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_req && armed && !at_end) |=> (count == $past(count) + 1'b1));

  // R9: once at the last beat the counter stays there until a load
  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && at_end) |=> (at_end && $stable(count)));

  // R11: no advance happens before the first load
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !armed) |=> (count == '0));
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0]        base_lo,
  input  logic [CNT_W-1:0]        count,
  input  bas_pkg::burst_order_e   order,
  output logic [CNT_W-1:0]        beat_lo
);
  always_comb begin
    case (order)
      bas_pkg::ORD_WRAP: beat_lo = base_lo + count;
      default:           beat_lo = base_lo ^ count;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              lin_mode,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic                  load_w;
  logic                  adv_w;
  logic [CNT_W-1:0]      count_w;
  logic                  armed_w;
  logic                  at_end_w;
  logic [CNT_W-1:0]      beat_lo_w;
  logic [ADDR_W-1:0]     base_q;
  bas_pkg::burst_order_e order_q;

  bas_strobe_ctrl u_strobe (
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .chip_en_n  (chip_en_n),
    .adv_n      (adv_n),
    .load       (load_w),
    .adv_req    (adv_w)
  );

  bas_beat_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_w),
    .adv_req (adv_w),
    .count   (count_w),
    .armed   (armed_w),
    .at_end  (at_end_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= bas_pkg::ORD_XOR;
    end else if (load_w) begin
      base_q  <= addr_in;
      order_q <= lin_mode ? bas_pkg::ORD_WRAP : bas_pkg::ORD_XOR;
    end
  end

  bas_order_map #(.CNT_W(CNT_W)) u_map (
    .base_lo (base_q[CNT_W-1:0]),
    .count   (count_w),
    .order   (order_q),
    .beat_lo (beat_lo_w)
  );

  always_comb begin
    addr_out  = {base_q[ADDR_W-1:CNT_W], beat_lo_w};
    last_beat = at_end_w;
  end

  // R2: the controller strobe always loads the sampled address
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_ctrl_n |=> (addr_out == $past(addr_in) && !last_beat));

  // R4: the processor strobe is ignored while the chip enable is inactive
  assert_proc_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_ctrl_n && !ads_proc_n && chip_en_n && adv_n)
      |=> ($stable(addr_out) && $stable(last_beat)));

  // R8: the upper bits change only through a load
  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_w |=> $stable(addr_out[ADDR_W-1:CNT_W]));

  // R10: a strobe beats an advance in the same cycle
  assert_strobe_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_ctrl_n && !adv_n) |=> (addr_out[CNT_W-1:0] == $past(addr_in[CNT_W-1:0])));

  // R5: with no strobe and no advance the address holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_ctrl_n && (ads_proc_n || chip_en_n) && adv_n) |=> $stable(addr_out));

  // suppress width mismatch concerns for the derived width
  initial begin
    assert_width_R8: assert (HI_W > 0);
  end
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              ads_proc_n = 1'b1;
  logic              ads_ctrl_n = 1'b1;
  logic              chip_en_n = 1'b1;
  logic              adv_n = 1'b1;
  logic              lin_mode = 1'b0;
  logic [ADDR_W-1:0] addr_out;
  logic              last_beat;

  int vectors = 0;
  int misses  = 0;

  // reference state
  int m_base = 0;
  int m_cnt = 0;
  int m_armed = 0;
  int m_lin = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ads_proc_n(ads_proc_n),
    .ads_ctrl_n(ads_ctrl_n), .chip_en_n(chip_en_n), .adv_n(adv_n),
    .lin_mode(lin_mode), .addr_out(addr_out), .last_beat(last_beat)
  );

  function automatic int exp_addr();
    int lo;
    if (m_lin != 0) lo = (m_base + m_cnt) % 4;
    else            lo = (m_base % 4) ^ m_cnt;
    return (m_base - (m_base % 4)) + lo;
  endfunction

  task automatic compare(input string tag);
    int ea;
    int el;
    ea = exp_addr();
    el = (m_armed != 0 && m_cnt == 3) ? 1 : 0;
    vectors++;
    if (int'(addr_out) != ea || int'(last_beat) != el) begin
      misses++;
      $display("FAIL %s: addr_out=%h last_beat=%0d expected addr_out=%h last_beat=%0d",
               tag, addr_out, last_beat, ea[ADDR_W-1:0], el);
    end
  endtask

  // drive one cycle of inputs, update the model at the edge, check at the next falling edge
  task automatic cyc(input int a, input bit ps, input bit cs, input bit ce,
                     input bit adv, input bit lm, input string tag);
    bit ld;
    addr_in = a[ADDR_W-1:0];
    ads_proc_n = ps; ads_ctrl_n = cs; chip_en_n = ce; adv_n = adv; lin_mode = lm;
    @(posedge clk);
    ld = (!ps && !ce) || !cs;
    if (rst_n == 1'b0) begin
      m_base = 0; m_cnt = 0; m_armed = 0; m_lin = 0;
    end else if (ld) begin
      m_base = a; m_cnt = 0; m_armed = 1; m_lin = lm;
    end else if (!adv && m_armed != 0 && m_cnt != 3) begin
      m_cnt++;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(8 * 150000);
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 4; i++) cyc(18'h2aaaa, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
    rst_n = 1'b1;
    cyc(0, 1, 1, 1, 1, 0, "R1");
    // advance before any load
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1, 0, 0, "R11");
    // controller strobe with chip enable inactive, interleaved, base low 2
    cyc(18'h12346, 1, 0, 1, 1, 0, "R2");
    cyc(0, 1, 1, 1, 0, 1, "R6");
    cyc(0, 1, 1, 1, 1, 1, "R5");
    cyc(0, 1, 1, 1, 0, 0, "R6");
    cyc(0, 1, 1, 1, 0, 0, "R9");
    cyc(0, 1, 1, 1, 0, 0, "R9");
    cyc(0, 1, 1, 1, 0, 0, "R8");
    // processor strobe gated off
    cyc(18'h0ffff, 0, 1, 1, 1, 0, "R4");
    // processor strobe accepted, linear, base low 3
    cyc(18'h3c0f3, 0, 1, 0, 1, 1, "R3");
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, 0, 0, "R7");
    // strobe together with advance
    cyc(18'h00005, 1, 0, 0, 0, 0, "R10");
    cyc(18'h00009, 0, 1, 0, 0, 1, "R10");
    cyc(0, 1, 1, 1, 0, 0, "R7");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      cyc(int'($urandom_range(0, 262143)), 1'($urandom_range(0, 3) == 0),
          1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)), "R5");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule